// File: doc/BRIEF.md
# Chained Mask/Value Sample Trigger

This block watches a stream of sample words from a logic capture front end and decides when the capture should fire. It holds a small chain of trigger stages. Each stage has a mask that picks the channels it cares about, a value that gives the required level of each picked channel, a level number and a fire flag. A stage takes part only once the chain's progress counter has reached that stage's level number. A stage without the fire flag moves the progress counter on by one when it matches. A stage with the fire flag produces a single-cycle trigger pulse when it matches.

Software writes the stage registers through a byte-addressed write port, and each register bank has its own base address. Before each capture it strobes a clear, which wipes the chain progress, and then a run strobe, which arms the chain. With no real trigger wanted, stage 0 gets a zero mask and the fire flag. The capture then triggers on the first valid sample after run.

Top module: `trig_chain`

## Requirements
- R1: Stage s registers sit at address 0xC0+4s (mask), 0xC1+4s (value) and 0xC2+4s (config). A write to any other address, including 0xC3+4s and anything below 0xC0 or at or above 0xC0+4·NUM_STAGES, changes no stage.
- R2: A stage matches a sample when every channel with its mask bit at 1 equals the stage's value bit. Channels with a mask bit of 0 are don't-care, so a channel can be required to be 0 or 1.
- R3: In a config word, bits 23:16 carry the stage level (only the low log2(NUM_STAGES) bits are kept) and bit 27 is the fire flag. All other config bits are ignored.
- R4: A stage is evaluated only when the progress counter is at least its level. When eligible stages match and none of them has the fire flag, the counter advances by exactly one, saturating at NUM_STAGES-1.
- R5: When an eligible stage with the fire flag matches a valid sample, trig_pulse is high for exactly one cycle, in the cycle after that sample. A firing match takes priority over advancing.
- R6: After a fire, no further pulse occurs until a clear. A run strobe without a clear does not re-arm.
- R7: A sample is ignored while smp_valid is low: no pulse and no change of progress.
- R8: clr_stb resets the progress to 0 and disarms the chain, keeping the stage registers. In its cycle no sample is evaluated and a simultaneous run is ignored.
- R9: Samples are evaluated only once armed. A run strobe arms from the next cycle, so a sample in the run cycle itself is not evaluated.
- R10: After rst, all stage registers are zero, the progress counter is 0, the chain is disarmed and trig_pulse is low.
- R11: With stage 0 set to a zero mask, level 0 and the fire flag, the first valid sample after run produces the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| run_stb | input | 1 | Arm the chain |
| clr_stb | input | 1 | Clear chain progress and disarm |
| smp_valid | input | 1 | Sample word valid |
| smp_data | input | 32 | Captured sample word |
| trig_pulse | output | 1 | Single-cycle trigger |

## Verification
The assertions assume that strobes and samples are synchronous, single-bit-clean and stable around the clock edge. They also assume that software follows every fire with a clear before expecting a new trigger, so the once-per-arming property is always checked against a clear. The stimulus drives all inputs on the falling edge, issues run and clear as one-cycle strobes, and includes runs with no clear between them, so both the disallowed re-arm and the clear path are exercised inside these assumptions.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

    // config word field positions (software-visible)
    localparam int CFG_LVL_LSB  = 16;
    localparam int CFG_FIRE_BIT = 27;

    // register bank selected by the low two address bits of a stage slot
    typedef enum logic [1:0] {
        BANK_MASK  = 2'd0,
        BANK_VALUE = 2'd1,
        BANK_CFG   = 2'd2,
        BANK_NONE  = 2'd3
    } bank_e;

    typedef struct packed {
        logic armed;
        logic fired;
    } seq_flags_t;

    function automatic logic stage_hit(input logic [31:0] smp,
                                       input logic [31:0] msk,
                                       input logic [31:0] val);
        return ((smp ^ val) & msk) == '0;
    endfunction

endpackage

// File: rtl/trig_regbank.sv
`timescale 1ns/1ps
module trig_regbank
    import trig_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int LVL_W      = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hC0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [31:0]                       wdata,
    output logic [NUM_STAGES-1:0][DATA_W-1:0] mask_q,
    output logic [NUM_STAGES-1:0][DATA_W-1:0] value_q,
    output logic [NUM_STAGES-1:0][LVL_W-1:0]  lvl_q,
    output logic [NUM_STAGES-1:0]             fire_q
);
    localparam int SEL_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_STAGES);

    logic [ADDR_W-1:0] offs;
    logic              in_win;
    logic [SEL_W-1:0]  sel;
    bank_e             bank;

    always_comb begin
        offs   = addr - BASE_ADDR;
        in_win = (addr >= BASE_ADDR) && (offs < SPAN);
        sel    = SEL_W'(offs >> 2);
        bank   = bank_e'(offs[1:0]);
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        logic hit_s;
        assign hit_s = we && in_win && (sel == SEL_W'(s));
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[s]  <= '0;
                value_q[s] <= '0;
                lvl_q[s]   <= '0;
                fire_q[s]  <= 1'b0;
            end else if (hit_s) begin
                case (bank)
                    BANK_MASK:  mask_q[s]  <= wdata[DATA_W-1:0];
                    BANK_VALUE: value_q[s] <= wdata[DATA_W-1:0];
                    BANK_CFG: begin
                        lvl_q[s]  <= wdata[CFG_LVL_LSB +: LVL_W];
                        fire_q[s] <= wdata[CFG_FIRE_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: writes outside the stage window leave every stage untouched
    a_r1_ignore_foreign_addr: assert property (@(posedge clk) disable iff (rst)
        (we && !in_win) |=> ($stable(mask_q) && $stable(value_q)
                              && $stable(lvl_q) && $stable(fire_q)));

    // R1: the unused fourth slot of a stage writes nothing
    a_r1_ignore_spare_slot: assert property (@(posedge clk) disable iff (rst)
        (we && in_win && bank == BANK_NONE) |=> ($stable(mask_q) && $stable(value_q)
                                                  && $stable(lvl_q) && $stable(fire_q)));

endmodule

// File: rtl/trig_stage_match.sv
`timescale 1ns/1ps
module trig_stage_match
    import trig_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 2
) (
    input  logic [DATA_W-1:0] smp,
    input  logic [DATA_W-1:0] msk,
    input  logic [DATA_W-1:0] val,
    input  logic [LVL_W-1:0]  stage_lvl,
    input  logic [LVL_W-1:0]  cur_lvl,
    input  logic              fire,
    output logic              hit_fire,
    output logic              hit_adv
);
    logic eligible;
    logic match;

    always_comb begin
        eligible = (stage_lvl <= cur_lvl);
        match    = stage_hit(32'(smp), 32'(msk), 32'(val));
        hit_fire = eligible && match && fire;
        hit_adv  = eligible && match && !fire;
    end
endmodule

// File: rtl/trig_sequencer.sv
`timescale 1ns/1ps
module trig_sequencer
    import trig_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int LVL_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  run,
    input  logic                  valid,
    input  logic [NUM_STAGES-1:0] hit_fire,
    input  logic [NUM_STAGES-1:0] hit_adv,
    output logic [LVL_W-1:0]      level_q,
    output logic                  trig_q
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_STAGES - 1);

    seq_flags_t flags_q;
    logic       eval;

    assign eval = flags_q.armed && !flags_q.fired && valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            level_q <= '0;
            trig_q  <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (clr) begin
                flags_q <= '0;
                level_q <= '0;
            end else begin
                if (run)
                    flags_q.armed <= 1'b1;
                if (eval) begin
                    if (|hit_fire) begin
                        trig_q        <= 1'b1;
                        flags_q.fired <= 1'b1;
                    end else if (|hit_adv && level_q != TOP_LVL) begin
                        level_q <= level_q + 1'b1;
                    end
                end
            end
        end
    end

    // R5: the trigger is a single-cycle pulse
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
        trig_q |=> !trig_q);
    // R6: once fired, silence until cleared
    a_r6_once_per_arming: assert property (@(posedge clk) disable iff (rst)
        (flags_q.fired && !clr) |=> !trig_q);
    // R7: invalid samples change nothing
    a_r7_invalid_idle: assert property (@(posedge clk) disable iff (rst)
        (!valid && !clr) |=> ($stable(level_q) && !trig_q));
    // R8: clear returns progress to zero without a pulse
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (level_q == '0 && !trig_q));
    // R4: progress only moves up by one, unless cleared
    a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (level_q == $past(level_q) || level_q == $past(level_q) + 1'b1));
    // R9: nothing happens before arming
    a_r9_needs_arm: assert property (@(posedge clk) disable iff (rst)
        !flags_q.armed |=> (!trig_q && $stable(level_q)));

endmodule

// File: rtl/trig_chain.sv
`timescale 1ns/1ps
module trig_chain
    import trig_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hC0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              run_stb,
    input  logic              clr_stb,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              trig_pulse
);
    localparam int LVL_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

    logic [NUM_STAGES-1:0][DATA_W-1:0] mask_q;
    logic [NUM_STAGES-1:0][DATA_W-1:0] value_q;
    logic [NUM_STAGES-1:0][LVL_W-1:0]  lvl_q;
    logic [NUM_STAGES-1:0]             fire_q;
    logic [NUM_STAGES-1:0]             hit_fire;
    logic [NUM_STAGES-1:0]             hit_adv;
    logic [LVL_W-1:0]                  level;

    trig_regbank #(
        .NUM_STAGES(NUM_STAGES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .LVL_W(LVL_W), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mask_q(mask_q), .value_q(value_q), .lvl_q(lvl_q), .fire_q(fire_q)
    );

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_cmp
        trig_stage_match #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_cmp (
            .smp(smp_data), .msk(mask_q[s]), .val(value_q[s]),
            .stage_lvl(lvl_q[s]), .cur_lvl(level), .fire(fire_q[s]),
            .hit_fire(hit_fire[s]), .hit_adv(hit_adv[s])
        );
    end

    trig_sequencer #(.NUM_STAGES(NUM_STAGES), .LVL_W(LVL_W)) u_seq (
        .clk(clk), .rst(rst), .clr(clr_stb), .run(run_stb), .valid(smp_valid),
        .hit_fire(hit_fire), .hit_adv(hit_adv), .level_q(level), .trig_q(trig_pulse)
    );

    // R10: no trigger in the cycle after reset is released
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !trig_pulse);

endmodule

// File: tb/sim_trig_chain.sv
`timescale 1ns/1ps
module sim_trig_chain;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        run_stb = 1'b0;
    logic        clr_stb = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        trig_pulse;

    int checks = 0;
    int errors = 0;
    int npulse = 0;
    string tag = "R10";

    always #2 clk = ~clk;

    trig_chain u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .run_stb(run_stb), .clr_stb(clr_stb),
        .smp_valid(smp_valid), .smp_data(smp_data), .trig_pulse(trig_pulse)
    );

    // behavioural reference model
    int unsigned m_mask [NS];
    int unsigned m_val  [NS];
    int          m_lvl  [NS];
    bit          m_fire [NS];
    int          m_level;
    bit          m_armed, m_fired, exp_pulse;

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++) begin
                m_mask[s] = 0; m_val[s] = 0; m_lvl[s] = 0; m_fire[s] = 0;
            end
            m_level = 0; m_armed = 0; m_fired = 0; exp_pulse = 0;
        end else begin
            bit hf, ha;
            exp_pulse = 0;
            if (clr_stb) begin
                m_level = 0; m_armed = 0; m_fired = 0;
            end else begin
                if (m_armed && !m_fired && smp_valid) begin
                    hf = 0; ha = 0;
                    for (int s = 0; s < NS; s++)
                        if (m_lvl[s] <= m_level && ((smp_data ^ m_val[s]) & m_mask[s]) == 0) begin
                            if (m_fire[s]) hf = 1; else ha = 1;
                        end
                    if (hf) begin exp_pulse = 1; m_fired = 1; end
                    else if (ha && m_level < NS - 1) m_level = m_level + 1;
                end
                if (run_stb) m_armed = 1;
            end
            if (cfg_we) begin
                int a;
                a = int'(cfg_addr);
                if (a >= 'hC0 && a < 'hC0 + 4 * NS) begin
                    case ((a - 'hC0) % 4)
                        0: m_mask[(a - 'hC0) / 4] = cfg_wdata;
                        1: m_val[(a - 'hC0) / 4]  = cfg_wdata;
                        2: begin
                            m_lvl[(a - 'hC0) / 4]  = int'(cfg_wdata[17:16]);
                            m_fire[(a - 'hC0) / 4] = cfg_wdata[27];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (trig_pulse !== exp_pulse) begin
            errors++;
            $display("FAIL %s: trig_pulse=%0b expected %0b at %0t", tag, trig_pulse, exp_pulse, $time);
        end
        if (trig_pulse === 1'b1) npulse++;
    end

    task automatic tick(); @(negedge clk); endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 0;
    endtask
    task automatic smp(input logic v, input logic [31:0] d);
        smp_valid = v; smp_data = d; tick(); smp_valid = 0;
    endtask
    task automatic do_run(); run_stb = 1; tick(); run_stb = 0; endtask
    task automatic do_clr(); clr_stb = 1; tick(); clr_stb = 0; endtask
    task automatic expect_count(input int n, input string t);
        #1;
        checks++;
        if (npulse != n) begin
            errors++;
            $display("FAIL %s: pulse count=%0d expected %0d", t, npulse, n);
        end
    endtask
    task automatic stage(input int s, input logic [31:0] m, input logic [31:0] v,
                         input int lv, input bit f);
        wr(8'(8'hC0 + 4 * s), m);
        wr(8'(8'hC1 + 4 * s), v);
        wr(8'(8'hC2 + 4 * s), (32'(lv) << 16) | (f ? 32'h0800_0000 : 32'h0));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) tick();
        rst = 0;
        tick();
        expect_count(0, "R10");

        // R11: immediate trigger, R3 fire flag at bit 27
        tag = "R11";
        do_clr();
        stage(0, 32'h0, 32'h0, 0, 1);
        do_run();
        smp(1, 32'h1234_5678);
        tick();
        expect_count(1, "R11");

        // R2/R4/R5: two-stage chain, stage 1 needs level 1
        tag = "R4";
        stage(0, 32'h0000_00FF, 32'h0000_0012, 0, 0);
        stage(1, 32'h0000_FF00, 32'h0000_3400, 1, 1);
        stage(2, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 3, 0);
        stage(3, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 3, 0);
        do_clr();
        run_stb = 1; smp_valid = 1; smp_data = 32'h0000_0012; tick(); // R9: run-cycle sample ignored
        run_stb = 0; smp_valid = 0;
        smp(1, 32'h0000_3400);            // stage 1 not yet eligible
        tick();
        expect_count(1, "R4");
        smp(1, 32'hFFFF_FF12);            // R2: don't-care bits, advances
        tag = "R7";
        smp(0, 32'h0000_3400);            // invalid, ignored
        tick();
        expect_count(1, "R7");
        tag = "R5";
        smp(1, 32'h0000_3400);
        tick();
        expect_count(2, "R5");
        // R6: no more pulses, run without clear does not re-arm
        tag = "R6";
        smp(1, 32'h0000_3400);
        do_run();
        smp(1, 32'h0000_3412);
        tick();
        expect_count(2, "R6");
        // R8: clear wipes progress, keeps registers; clr beats run
        tag = "R8";
        clr_stb = 1; run_stb = 1; tick(); clr_stb = 0; run_stb = 0;
        smp(1, 32'h0000_0012);            // not armed
        do_run();
        smp(1, 32'h0000_3400);            // level back at 0
        tick();
        expect_count(2, "R8");
        // R1: foreign addresses change nothing
        tag = "R1";
        wr(8'hC3, 32'hFFFF_FFFF);
        wr(8'hBF, 32'h0000_0000);
        wr(8'hD0, 32'h0800_0000);
        wr(8'hC7, 32'h0000_0000);
        smp(1, 32'h0000_0012);
        smp(1, 32'h0000_3400);
        tick();
        expect_count(3, "R1");

        // R3: level kept from low bits only, other config bits ignored
        tag = "R3";
        do_clr();
        wr(8'hC6, 32'hF7FD_0000);         // stage 1 level 1, fire 0, junk elsewhere
        wr(8'hC6, 32'h0805_0000);         // level field 5 -> 1, fire 1
        do_run();
        smp(1, 32'h0000_0012);
        smp(1, 32'h0000_3400);
        tick();
        expect_count(4, "R3");

        // R4/R5/R7 soak: saturation and mixed patterns against the model
        tag = "R4";
        stage(0, 32'h0000_0003, 32'h0000_0001, 0, 0);
        stage(1, 32'h0000_0030, 32'h0000_0020, 1, 0);
        stage(2, 32'h0000_0300, 32'h0000_0100, 2, 0);
        stage(3, 32'hC000_0000, 32'h4000_0000, 3, 1);
        begin
            logic [31:0] lf;
            lf = 32'hACE1_2357;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                if (i % 97 == 0) do_clr();
                else if (i % 97 == 1) do_run();
                else smp(lf[5], lf);
            end
        end
        repeat (3) tick();
        checks++;
        if (npulse < 5) begin
            errors++;
            $display("FAIL R5: soak pulse count=%0d expected at least 5", npulse);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule